// File: doc/BRIEF.md
# Memory Bank Chip-Select Decoder

This block sits between a bus master and a set of memory timing engines. It holds twelve programmable address windows. For each request it finds the window that contains the request address, drives that bank's chip select, and reports which timing engine should run the access. The engines are a general-purpose chip-select engine, three user-programmable engines (A, B, C) and an SDRAM engine. It also passes the bank's data-pipelining flag through to the chosen engine. It blocks writes to read-only banks and flags banks whose error-checking mode does not suit their port size. The timing engines and the parity or ECC arithmetic are outside this block.

Software programs each bank through a write port with two words per bank. The base word holds the window tag, the engine code, the write-protect bit and the valid bit. The option word holds the window mask, the checking mode, the port size and the pipelining flag. Requests use a valid/ready handshake. `req_ready` is low during reset and high in every cycle after it, so the block never applies back-pressure. A request is accepted in any cycle with `req_valid && req_ready`. Results appear on plain registered outputs one clock after acceptance and last one cycle. There is no downstream handshake.

Top module: `bank_select_decoder`

## Requirements
- R1: A bank hits when it is valid and `((req_addr ^ base) & mask) == 0` over the 17-bit tag, which is address bits 31:15. The result is registered: `cs` has the winning bank's bit set in the cycle after acceptance, for one cycle.
- R2: When several valid banks hit, only the lowest-numbered bank is selected, and `cs` never has more than one bit set.
- R3: A bank never hits if any of the following holds: its mask is not a run of ones starting at the MSB; its engine code is 5 to 7; or its engine code is SDRAM and its mask has fewer than 5 or more than 12 ones (windows of 128 MB down to 1 MB). A non-SDRAM mask may have 0 to 17 ones (4 GB down to 32 KB).
- R4: Alongside `cs`, `msel` carries the winning bank's engine code and `pipe_en` carries its pipelining flag. The codes are 0 = general-purpose, 1 = A, 2 = B, 3 = C and 4 = SDRAM. Both outputs are 0 when `cs` is 0.
- R5: Reset leaves bank 0 valid, with engine code 0, mask 0 (the whole 4 GB), 8-bit port and no checking. All other banks are cleared to invalid. All outputs are 0 and `req_ready` is 0 while reset is asserted.
- R6: A write whose winning bank is write-protected asserts no chip select and raises `wp_err` for one cycle. A read of the same bank is decoded normally.
- R7: `cfg_err` pulses with the access result when the winning bank's checking mode does not suit its port size. The illegal cases are read-modify-write parity (mode 2) on port size 0 or 1, and ECC (mode 3) on any port size other than 3. Port size codes are 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits; mode 0 is none and mode 1 is normal parity. `cfg_err` does not suppress the chip select.
- R8: An accepted request that hits no bank raises `no_hit` for one cycle and asserts no chip select.
- R9: When `cfg_we` is high, the register at `cfg_idx` is written at the clock edge. `cfg_sel` = 0 writes the base word `{tag[21:5], engine[4:2], wp[1], valid[0]}`; `cfg_sel` = 1 writes the option word `{mask[21:5], mode[4:3], size[2:1], pipe[0]}`. Writes to an index of 12 or more are ignored. A request accepted in the same cycle as a write decodes the old contents. In a cycle after no accepted request, all outputs are 0. `req_ready` is 1 whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = base word, 1 = option word |
| cfg_idx | input | 4 | Bank index |
| cfg_wdata | input | 22 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (high out of reset) |
| req_addr | input | 17 | Address bits 31:15 of the request |
| req_write | input | 1 | 1 = write access |
| cs | output | 12 | Chip selects, one per bank |
| msel | output | 3 | Engine code of the selected bank |
| pipe_en | output | 1 | Pipelining flag of the selected bank |
| wp_err | output | 1 | Write to a read-only bank |
| cfg_err | output | 1 | Checking mode illegal for port size |
| no_hit | output | 1 | Request matched no bank |

## Verification
A register write and a request can land in the same clock edge. The bench provokes this by rewriting bank 0's valid bit while it presents a request inside bank 0's window, and it expects the decode that the previous contents give. The following access must then follow the new contents. A second collision happens inside one access: a write to a bank that is both write-protected and misconfigured must raise `wp_err` and `cfg_err` together with no chip select. A bench-side model derived from the window, priority and legality rules judges both collisions, and it also judges sweeps over every bank's window edges and randomly overlapping configurations.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int TAG_W  = 17;
  localparam int ATTR_W = 5;
  localparam int CFG_W  = TAG_W + ATTR_W;

  localparam logic [2:0] MS_GPCM  = 3'd0;
  localparam logic [2:0] MS_SDRAM = 3'd4;
  localparam logic [1:0] CHK_RMW  = 2'd2;
  localparam logic [1:0] CHK_ECC  = 2'd3;
  localparam logic [1:0] PS_32    = 2'd2;
  localparam logic [1:0] PS_64    = 2'd3;

  typedef struct packed {
    logic [TAG_W-1:0] base;
    logic [TAG_W-1:0] mask;
    logic [2:0]       msel;
    logic [1:0]       chk;
    logic [1:0]       psize;
    logic             pipe;
    logic             wp;
    logic             valid;
  } bank_cfg_t;
endpackage

// File: rtl/bsd_regs.sv
module bsd_regs
  import bsd_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               sel,
  input  logic [IDX_W-1:0]   idx,
  input  logic [CFG_W-1:0]   wdata,
  output bank_cfg_t          cfg_q [NUM_BANKS]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) cfg_q[b] <= '0;
      cfg_q[0].valid <= 1'b1;
      cfg_q[0].msel  <= MS_GPCM;
    end else if (we) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(idx) == b) begin
          if (sel) begin
            cfg_q[b].mask  <= wdata[CFG_W-1 -: TAG_W];
            cfg_q[b].chk   <= wdata[4:3];
            cfg_q[b].psize <= wdata[2:1];
            cfg_q[b].pipe  <= wdata[0];
          end else begin
            cfg_q[b].base  <= wdata[CFG_W-1 -: TAG_W];
            cfg_q[b].msel  <= wdata[4:2];
            cfg_q[b].wp    <= wdata[1];
            cfg_q[b].valid <= wdata[0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/bsd_bank_match.sv
module bsd_bank_match
  import bsd_pkg::*;
#(
  parameter int SD_MIN_ONES = 5,
  parameter int SD_MAX_ONES = 12
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] base,
  input  logic [TAG_W-1:0] mask,
  input  logic [2:0]       msel,
  input  logic [1:0]       chk,
  input  logic [1:0]       psize,
  input  logic [TAG_W-1:0] tag,
  output logic             hit,
  output logic             chk_bad
);
  logic [TAG_W-1:0] inv;
  logic             contig, size_ok, code_ok;
  int               ones;

  always_comb begin
    inv     = ~mask;
    contig  = ((inv & (inv + TAG_W'(1))) == '0);
    ones    = $countones(mask);
    code_ok = (msel <= MS_SDRAM);
    size_ok = (msel != MS_SDRAM) || (ones >= SD_MIN_ONES && ones <= SD_MAX_ONES);
    hit     = valid && code_ok && contig && size_ok && (((tag ^ base) & mask) == '0);
    chk_bad = ((chk == CHK_RMW) && (psize < PS_32)) ||
              ((chk == CHK_ECC) && (psize != PS_64));
  end
endmodule

// File: rtl/bsd_pick.sv
module bsd_pick #(
  parameter int NUM_BANKS = 12,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_BANKS-1:0] req,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bank_select_decoder.sv
module bank_select_decoder
  import bsd_pkg::*;
#(
  parameter int NUM_BANKS   = 12,
  parameter int SD_MIN_ONES = 5,
  parameter int SD_MAX_ONES = 12,
  localparam int IDX_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [TAG_W-1:0]     req_addr,
  input  logic                 req_write,
  output logic [NUM_BANKS-1:0] cs,
  output logic [2:0]           msel,
  output logic                 pipe_en,
  output logic                 wp_err,
  output logic                 cfg_err,
  output logic                 no_hit
);
  bank_cfg_t            cfg [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit, chk_bad;
  logic                 any_hit, accept;
  logic [IDX_W-1:0]     win;
  bank_cfg_t            win_cfg;

  bsd_regs #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel),
    .idx(cfg_idx), .wdata(cfg_wdata), .cfg_q(cfg)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bsd_bank_match #(.SD_MIN_ONES(SD_MIN_ONES), .SD_MAX_ONES(SD_MAX_ONES)) u_match (
      .valid(cfg[g].valid), .base(cfg[g].base), .mask(cfg[g].mask),
      .msel(cfg[g].msel), .chk(cfg[g].chk), .psize(cfg[g].psize),
      .tag(req_addr), .hit(hit[g]), .chk_bad(chk_bad[g])
    );
  end

  bsd_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
    .req(hit), .any(any_hit), .idx(win)
  );

  assign accept  = req_valid && req_ready;
  assign win_cfg = cfg[win];

  always_ff @(posedge clk) begin
    if (rst) req_ready <= 1'b0;
    else     req_ready <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs <= '0; msel <= '0; pipe_en <= 1'b0;
      wp_err <= 1'b0; cfg_err <= 1'b0; no_hit <= 1'b0;
    end else begin
      cs <= '0; msel <= '0; pipe_en <= 1'b0;
      wp_err <= 1'b0; cfg_err <= 1'b0; no_hit <= 1'b0;
      if (accept) begin
        if (!any_hit) begin
          no_hit <= 1'b1;
        end else begin
          cfg_err <= chk_bad[win];
          if (req_write && win_cfg.wp) begin
            wp_err <= 1'b1;
          end else begin
            cs[win] <= 1'b1;
            msel    <= win_cfg.msel;
            pipe_en <= win_cfg.pipe;
          end
        end
      end
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(cs)); // R2
  AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (rst) no_hit |-> (cs == '0 && !wp_err && !cfg_err)); // R8
  AST_WP_BLOCKS_CS: assert property (@(posedge clk) disable iff (rst) wp_err |-> (cs == '0)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !accept |=> (cs == '0 && !no_hit && !wp_err && !cfg_err)); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst) accept |=> ($countones({cs != '0, wp_err, no_hit}) == 1)); // R1
  AST_MSEL_IDLE: assert property (@(posedge clk) disable iff (rst) (cs == '0) |-> (msel == '0 && !pipe_en)); // R4
  AST_MSEL_LEGAL: assert property (@(posedge clk) disable iff (rst) (cs != '0) |-> (msel <= MS_SDRAM)); // R3
endmodule

// File: tb/test_bank_select_decoder.sv
module test_bank_select_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_sel;
  logic [3:0]  cfg_idx;
  logic [21:0] cfg_wdata;
  logic        req_valid, req_ready, req_write;
  logic [16:0] req_addr;
  logic [NB-1:0] cs;
  logic [2:0]  msel;
  logic        pipe_en, wp_err, cfg_err, no_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [16:0] m_base [NB];
  logic [16:0] m_mask [NB];
  logic [2:0]  m_ms   [NB];
  logic [1:0]  m_chk  [NB];
  logic [1:0]  m_ps   [NB];
  logic        m_pipe [NB];
  logic        m_wp   [NB];
  logic        m_val  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_select_decoder i_bank_select_decoder (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cs(cs), .msel(msel),
    .pipe_en(pipe_en), .wp_err(wp_err), .cfg_err(cfg_err), .no_hit(no_hit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] observed();
    return {cs, msel, pipe_en, wp_err, cfg_err, no_hit};
  endfunction

  function automatic logic [18:0] model(input logic [31:0] a, input logic wr, output int nh);
    logic [NB-1:0] c = '0;
    logic [16:0] t = a[31:15];
    logic [16:0] inv;
    int w = -1;
    nh = 0;
    for (int i = 0; i < NB; i++) begin
      int k = $countones(m_mask[i]);
      bit ok;
      inv = ~m_mask[i];
      ok = m_val[i] && (m_ms[i] <= 3'd4) && ((inv & (inv + 17'd1)) == 17'd0) &&
           (m_ms[i] != 3'd4 || (k >= 5 && k <= 12)) && (((t ^ m_base[i]) & m_mask[i]) == 17'd0);
      if (ok) begin nh++; if (w < 0) w = i; end
    end
    if (w < 0) return {12'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1};
    begin
      bit bad = (m_chk[w] == 2'd2 && m_ps[w] < 2'd2) || (m_chk[w] == 2'd3 && m_ps[w] != 2'd3);
      if (wr && m_wp[w]) return {12'd0, 3'd0, 1'b0, 1'b1, bad, 1'b0};
      c[w] = 1'b1;
      return {c, m_ms[w], m_pipe[w], 1'b0, bad, 1'b0};
    end
  endfunction

  function automatic string auto_tag(input logic [18:0] e, input int nh);
    if (e[0]) return "R8";
    if (e[2]) return "R6";
    if (e[1]) return "R7";
    if (nh > 1) return "R2";
    return "R1";
  endfunction

  task automatic access(input logic [31:0] a, input logic wr, input string lbl);
    logic [18:0] e;
    int nh;
    string tg;
    e = model(a, wr, nh);
    req_valid = 1'b1; req_addr = a[31:15]; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    tg = (lbl == "") ? auto_tag(e, nh) : lbl;
    check(observed() == e, tg, 32'(observed()), 32'(e));
  endtask

  task automatic cfg_write(input bit sel, input int idx, input logic [21:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_bank(input int i, input logic [16:0] b, input logic [16:0] m, input logic [2:0] ms,
                          input logic [1:0] ps, input logic [1:0] ck, input logic wp, input logic pp, input logic v);
    cfg_write(1'b0, i, {b, ms, wp, v});
    cfg_write(1'b1, i, {m, ck, ps, pp});
    m_base[i] = b; m_mask[i] = m; m_ms[i] = ms; m_ps[i] = ps;
    m_chk[i] = ck; m_wp[i] = wp; m_pipe[i] = pp; m_val[i] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_idx = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; req_write = 0;
    for (int i = 0; i < NB; i++) begin
      m_base[i] = 0; m_mask[i] = 0; m_ms[i] = 0; m_ps[i] = 0;
      m_chk[i] = 0; m_wp[i] = 0; m_pipe[i] = 0; m_val[i] = (i == 0);
    end
    repeat (3) @(negedge clk);
    check(observed() == 19'd0 && !req_ready, "R5", {12'd0, req_ready, observed()}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", 32'(req_ready), 32'd1);

    // R5: boot bank 0 covers the whole space with the general-purpose engine
    access(32'hDEAD_0000, 1'b0, "R5");
    access(32'h0000_0000, 1'b1, "R5");
    @(negedge clk);
    check(observed() == 19'd0, "R9", 32'(observed()), 32'd0);

    // Tile the space: bank i is a 128 MB window at i * 128 MB
    for (int i = 0; i < NB; i++)
      set_bank(i, 17'(i << 12), 17'h1F000, 3'(i % 5), 2'(i % 4), 2'((i / 4) % 4),
               (i % 3) == 2, i[0], 1'b1);
    // R1/R4/R6/R7/R8: sweep window edges, reads and writes
    for (int i = 0; i < 16; i++) begin
      access(32'(i) << 27, 1'b0, "");
      access((32'(i) << 27) | 32'h07FF_FFFF, 1'b0, "");
      access((32'(i) << 27) | 32'h0400_0000, 1'b1, "");
    end
    access(32'h2000_0000, 1'b0, "R4"); // SDRAM bank 4
    access(32'h0800_0000, 1'b0, "R4"); // bank 1, pipelined
    // R6 and R7 on one access: bank 8 is read-only with illegal RMW parity
    access(32'h4000_0000, 1'b1, "R6");
    access(32'h4000_0000, 1'b0, "R7");
    // R7: ECC on a 16-bit port, then on a 64-bit port
    set_bank(1, 17'h01000, 17'h1F000, 3'd1, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1);
    access(32'h0800_0000, 1'b0, "R7");
    set_bank(1, 17'h01000, 17'h1F000, 3'd1, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1);
    access(32'h0800_0000, 1'b0, "R7");

    // R2: bank 2 widened to 1 GB from zero overlaps banks 0-7
    set_bank(2, 17'h00000, 17'h18000, 3'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h3000_0000, 1'b0, "R2");
    access(32'h0000_1000, 1'b0, "R2");
    access(32'h0800_1000, 1'b0, "R2");
    set_bank(2, 17'h02000, 17'h1F000, 3'd2, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);

    // R3: window legality
    set_bank(8, 17'h08000, 17'h1F001, 3'd3, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h4000_0000, 1'b0, "R3");
    set_bank(9, 17'h09000, 17'h1FFF8, 3'd4, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h4800_0000, 1'b0, "R3");
    set_bank(4, 17'h04000, 17'h1FFE0, 3'd4, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h200F_FFFF, 1'b0, "R3");
    access(32'h2010_0000, 1'b0, "R3");
    set_bank(4, 17'h04000, 17'h1E000, 3'd4, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h2000_0000, 1'b0, "R3");
    set_bank(10, 17'h0A000, 17'h1FFFF, 3'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h5000_7FFF, 1'b0, "R3");
    access(32'h5000_8000, 1'b0, "R3");
    set_bank(11, 17'h0B000, 17'h1F000, 3'd5, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    access(32'h5800_0000, 1'b0, "R3");

    // R9: write to an out-of-range index leaves all banks unchanged
    cfg_write(1'b0, 13, 22'h0);
    access(32'h0000_0000, 1'b0, "R9");
    // R9: a write and a request in the same cycle; the request sees the old bank 0
    begin
      logic [18:0] e;
      int nh;
      e = model(32'h0000_2000, 1'b0, nh);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_idx = 4'd0; cfg_wdata = {17'h00000, 3'd0, 1'b0, 1'b0};
      req_valid = 1'b1; req_addr = 17'h00000; req_write = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      m_val[0] = 1'b0;
      check(observed() == e, "R9", 32'(observed()), 32'(e));
    end
    access(32'h0000_2000, 1'b0, "R9");

    // Random overlapping configurations
    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < NB; i++) begin
        logic [16:0] mk;
        int k = $urandom % 18;
        mk = ~(17'h1FFFF >> k);
        if ($urandom % 6 == 0) mk = 17'($urandom);
        set_bank(i, {3'($urandom), 14'($urandom)}, mk, 3'($urandom % 6), 2'($urandom),
                 2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) != 0);
      end
      for (int j = 0; j < 40; j++) begin
        int b = $urandom % NB;
        logic [31:0] a = {m_base[b], 15'($urandom)};
        if ($urandom % 3 == 0) a = a ^ (32'd1 << ($urandom % 32));
        access(a, 1'($urandom), "");
      end
    end
    finish_run();
  end
endmodule